// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes and commits the control-register side effects a small processor core needs when it enters an exception or an interrupt. A one-cycle request carries a 5-bit exception code. The core also supplies the current PC, the instruction word at that PC, the live status, cause and TLB-control values, and two vector addresses: one for general exceptions and one for fast TLB misses.

One clock edge after the request, the block presents the new values for each register it affects, together with an 8-bit write-enable vector. The core's register file applies these values, and registers whose enable is low keep their contents. The block covers the following cases:
- nested exceptions, where the exception-handling flag was already set, so saving state is skipped;
- first and double TLB misses;
- a separate save pair for breakpoints;
- a semihosting break word, which only advances the PC.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `done_o`, `semihost_o`, `err_o` and every bit of `we_o` are 0.
- R2: A request sampled at a clock edge produces, on that same edge, all new register values, `we_o` and `done_o`. `done_o` stays high for exactly one cycle. `we_o` bit order, MSB first, is: status, saved status, break status, cause, TLB control, return address, break return, PC.
- R3: Code 1 is an interrupt. Status bits are: bit0 interrupt enable (IE), bit1 user mode (U), bit2 exception-handling (EH), bit3 interrupt-handling (IH). With IE set, the block saves status, sets IH, clears IE and U, writes return address = PC+4 and jumps to the general vector. With IE clear, nothing is written, but `done_o` still pulses.
- R4: Every recognised exception other than a semihost break writes its code into cause bits [6:2] and keeps all other cause bits.
- R5: Code 2 (TLB miss) with EH clear is a fast miss. The block saves status, sets EH, clears IE and U, clears TLB-control bit1 (double flag), sets TLB-control bit0 (write flag), writes return address = PC+4 and jumps to the fast-miss vector.
- R6: Code 2 with EH set is a double miss. The block sets the double flag, sets EH, clears IE and U and jumps to the general vector. Saved status and return address are not written.
- R7: Codes 3, 4 and 5 (read, write and execute permission faults) always save status and return address = PC+4, set EH, clear IE and U, and jump to the general vector.
- R8: Codes 6 to 10 (supervisor address, supervisor instruction, supervisor data, illegal instruction, trap) save status and return address only when EH was clear. Every one of them sets EH, clears IE and U and jumps to the general vector.
- R9: Code 11 (break) writes break status and break return = PC+4 instead of the normal save pair, and only when EH was clear. It otherwise behaves as in R8.
- R10: Code 11 with `semihost_en_i` high and `insn_i` = 0x003DA07A writes only PC = PC+4 and pulses `semihost_o` for one cycle.
- R11: Codes 0 and 12 to 31 set `err_o`, which stays set until reset, and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle exception request |
| code_i | input | 5 | Exception code |
| pc_i | input | 32 | PC of the excepting instruction |
| insn_i | input | 32 | Instruction word at `pc_i` |
| semihost_en_i | input | 1 | Semihosting enabled |
| exc_vec_i | input | 32 | General exception vector |
| tlb_vec_i | input | 32 | Fast TLB-miss vector |
| status_i | input | 32 | Current status |
| cause_i | input | 32 | Current cause register |
| tlbmisc_i | input | 32 | Current TLB-control register |
| we_o | output | 8 | Write enables (order in R2) |
| status_o | output | 32 | New status |
| estatus_o | output | 32 | New saved status |
| bstatus_o | output | 32 | New break status |
| cause_o | output | 32 | New cause |
| tlbmisc_o | output | 32 | New TLB control |
| ea_o | output | 32 | New return address |
| ba_o | output | 32 | New break return address |
| pc_o | output | 32 | New PC |
| semihost_o | output | 1 | Semihost break taken |
| done_o | output | 1 | Commit pulse |
| err_o | output | 1 | Sticky unknown-code flag |

## Verification
The assertions assume that `req_i` is a single-cycle pulse and that the core holds `pc_i` stable across the request edge. They also assume the status image given with a request is the one the core will overwrite. The bench drives each request for exactly one cycle, between falling edges, and separates requests by idle cycles. It also gives every request a fresh, fully defined set of register inputs, so `done_o` never overlaps and every return-address check refers to the PC of the same request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W    = 5;
  localparam int CAUSE_LSB = 2;
  localparam int ST_IE     = 0;
  localparam int ST_U      = 1;
  localparam int ST_EH     = 2;
  localparam int ST_IH     = 3;
  localparam int TM_WR     = 0;
  localparam int TM_DBL    = 1;

  typedef enum logic [2:0] {
    CL_IRQ, CL_TLBMISS, CL_PERM, CL_NEST, CL_BREAK, CL_BAD
  } exc_class_e;

  typedef struct packed {
    logic status;
    logic estatus;
    logic bstatus;
    logic cause;
    logic tlbmisc;
    logic ea;
    logic ba;
    logic pc;
  } we_t;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output exc_class_e        cls_o
);
  always_comb begin
    unique case (code_i)
      5'd1:                       cls_o = CL_IRQ;
      5'd2:                       cls_o = CL_TLBMISS;
      5'd3, 5'd4, 5'd5:           cls_o = CL_PERM;
      5'd6, 5'd7, 5'd8, 5'd9, 5'd10: cls_o = CL_NEST;
      5'd11:                      cls_o = CL_BREAK;
      default:                    cls_o = CL_BAD;
    endcase
  end
endmodule

// File: rtl/exc_effects.sv
module exc_effects
  import exc_entry_pkg::*;
#(
  parameter int          DW        = 32,
  parameter logic [31:0] SEMI_WORD = 32'h003D_A07A
) (
  input  exc_class_e        cls_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DW-1:0]     pc_i,
  input  logic [31:0]       insn_i,
  input  logic              semihost_en_i,
  input  logic [DW-1:0]     exc_vec_i,
  input  logic [DW-1:0]     tlb_vec_i,
  input  logic [DW-1:0]     status_i,
  input  logic [DW-1:0]     cause_i,
  input  logic [DW-1:0]     tlbmisc_i,
  output we_t               we_o,
  output logic [DW-1:0]     status_o,
  output logic [DW-1:0]     estatus_o,
  output logic [DW-1:0]     bstatus_o,
  output logic [DW-1:0]     cause_o,
  output logic [DW-1:0]     tlbmisc_o,
  output logic [DW-1:0]     ea_o,
  output logic [DW-1:0]     ba_o,
  output logic [DW-1:0]     pc_o,
  output logic              semi_o,
  output logic              bad_o
);
  localparam logic [DW-1:0] M_IE  = DW'(1) << ST_IE;
  localparam logic [DW-1:0] M_U   = DW'(1) << ST_U;
  localparam logic [DW-1:0] M_EH  = DW'(1) << ST_EH;
  localparam logic [DW-1:0] M_IH  = DW'(1) << ST_IH;
  localparam logic [DW-1:0] M_WR  = DW'(1) << TM_WR;
  localparam logic [DW-1:0] M_DBL = DW'(1) << TM_DBL;

  logic [DW-1:0] pc_plus4;
  logic          eh;

  assign pc_plus4 = pc_i + DW'(4);
  assign eh       = status_i[ST_EH];

  always_comb begin
    we_o      = '0;
    semi_o    = 1'b0;
    bad_o     = 1'b0;
    status_o  = (status_i | M_EH) & ~(M_IE | M_U);
    estatus_o = status_i;
    bstatus_o = status_i;
    cause_o   = cause_i;
    cause_o[CAUSE_LSB +: CODE_W] = code_i;
    tlbmisc_o = tlbmisc_i;
    ea_o      = pc_plus4;
    ba_o      = pc_plus4;
    pc_o      = exc_vec_i;
    unique case (cls_i)
      CL_IRQ: if (status_i[ST_IE]) begin
        status_o   = (status_i | M_IH) & ~(M_IE | M_U);
        we_o.status  = 1'b1;
        we_o.estatus = 1'b1;
        we_o.cause   = 1'b1;
        we_o.ea      = 1'b1;
        we_o.pc      = 1'b1;
      end
      CL_TLBMISS: begin
        we_o.status  = 1'b1;
        we_o.cause   = 1'b1;
        we_o.tlbmisc = 1'b1;
        we_o.pc      = 1'b1;
        if (!eh) begin
          tlbmisc_o    = (tlbmisc_i & ~M_DBL) | M_WR;
          pc_o         = tlb_vec_i;
          we_o.estatus = 1'b1;
          we_o.ea      = 1'b1;
        end else begin
          tlbmisc_o    = tlbmisc_i | M_DBL;
        end
      end
      CL_PERM: begin
        we_o.status  = 1'b1;
        we_o.estatus = 1'b1;
        we_o.cause   = 1'b1;
        we_o.ea      = 1'b1;
        we_o.pc      = 1'b1;
      end
      CL_NEST: begin
        we_o.status  = 1'b1;
        we_o.cause   = 1'b1;
        we_o.pc      = 1'b1;
        we_o.estatus = !eh;
        we_o.ea      = !eh;
      end
      CL_BREAK: begin
        if (semihost_en_i && insn_i == SEMI_WORD) begin
          pc_o    = pc_plus4;
          we_o.pc = 1'b1;
          semi_o  = 1'b1;
        end else begin
          we_o.status  = 1'b1;
          we_o.cause   = 1'b1;
          we_o.pc      = 1'b1;
          we_o.bstatus = !eh;
          we_o.ba      = !eh;
        end
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          DW        = 32,
  parameter logic [31:0] SEMI_WORD = 32'h003D_A07A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DW-1:0]     pc_i,
  input  logic [31:0]       insn_i,
  input  logic              semihost_en_i,
  input  logic [DW-1:0]     exc_vec_i,
  input  logic [DW-1:0]     tlb_vec_i,
  input  logic [DW-1:0]     status_i,
  input  logic [DW-1:0]     cause_i,
  input  logic [DW-1:0]     tlbmisc_i,
  output logic [7:0]        we_o,
  output logic [DW-1:0]     status_o,
  output logic [DW-1:0]     estatus_o,
  output logic [DW-1:0]     bstatus_o,
  output logic [DW-1:0]     cause_o,
  output logic [DW-1:0]     tlbmisc_o,
  output logic [DW-1:0]     ea_o,
  output logic [DW-1:0]     ba_o,
  output logic [DW-1:0]     pc_o,
  output logic              semihost_o,
  output logic              done_o,
  output logic              err_o
);
  exc_class_e    cls;
  we_t           n_we, we_q;
  logic [DW-1:0] n_st, n_est, n_bst, n_cause, n_tm, n_ea, n_ba, n_pc;
  logic          n_semi, n_bad;

  exc_classify u_classify (.code_i(code_i), .cls_o(cls));

  exc_effects #(.DW(DW), .SEMI_WORD(SEMI_WORD)) u_effects (
    .cls_i(cls), .code_i(code_i), .pc_i(pc_i), .insn_i(insn_i),
    .semihost_en_i(semihost_en_i), .exc_vec_i(exc_vec_i), .tlb_vec_i(tlb_vec_i),
    .status_i(status_i), .cause_i(cause_i), .tlbmisc_i(tlbmisc_i),
    .we_o(n_we), .status_o(n_st), .estatus_o(n_est), .bstatus_o(n_bst),
    .cause_o(n_cause), .tlbmisc_o(n_tm), .ea_o(n_ea), .ba_o(n_ba), .pc_o(n_pc),
    .semi_o(n_semi), .bad_o(n_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q       <= '0;
      done_o     <= 1'b0;
      semihost_o <= 1'b0;
      err_o      <= 1'b0;
      status_o   <= '0;
      estatus_o  <= '0;
      bstatus_o  <= '0;
      cause_o    <= '0;
      tlbmisc_o  <= '0;
      ea_o       <= '0;
      ba_o       <= '0;
      pc_o       <= '0;
    end else begin
      done_o     <= req_i;
      we_q       <= req_i ? n_we : '0;
      semihost_o <= req_i & n_semi;
      if (req_i && n_bad) err_o <= 1'b1;
      if (req_i) begin
        status_o  <= n_st;
        estatus_o <= n_est;
        bstatus_o <= n_bst;
        cause_o   <= n_cause;
        tlbmisc_o <= n_tm;
        ea_o      <= n_ea;
        ba_o      <= n_ba;
        pc_o      <= n_pc;
      end
    end
  end

  assign we_o = we_q;

  // R2: every request commits one cycle later
  assert_done_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  // R3 R5 R7 R8 R9: any status write leaves IE and U clear
  assert_status_masks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o[7] |-> (!status_o[ST_IE] && !status_o[ST_U]));
  // R10: semihost break writes only the PC
  assert_semihost_pc_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    semihost_o |-> (we_o == 8'b0000_0001));
  // R11: error flag is sticky
  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R5 R7: return address is the request PC plus 4
  assert_ea_pc_plus4_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && $stable(pc_i)) |=> (!we_o[2] || ea_o == $past(pc_i) + DW'(4)));
  // R6: double-miss flag never appears with a status save
  assert_double_no_save_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o[3] && tlbmisc_o[TM_DBL]) |-> !we_o[6]);
  // R11: unknown-code requests write nothing
  assert_bad_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && n_bad) |=> (we_o == 8'b0));
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [4:0]  code_i = '0;
  logic [31:0] pc_i = '0, insn_i = '0;
  logic        semihost_en_i = 1'b0;
  logic [31:0] exc_vec_i = 32'h0000_0120, tlb_vec_i = 32'h0100_0000;
  logic [31:0] status_i = '0, cause_i = 32'hA5A5_A5A7, tlbmisc_i = 32'h0000_F0F2;
  logic [7:0]  we_o;
  logic [31:0] status_o, estatus_o, bstatus_o, cause_o, tlbmisc_o, ea_o, ba_o, pc_o;
  logic        semihost_o, done_o, err_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  localparam logic [31:0] IE = 32'h1, U = 32'h2, EH = 32'h4, IH = 32'h8;
  localparam logic [31:0] WRB = 32'h1, DBL = 32'h2;
  localparam logic [31:0] MAGIC = 32'h003D_A07A;

  always #10 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .code_i(code_i), .pc_i(pc_i),
    .insn_i(insn_i), .semihost_en_i(semihost_en_i), .exc_vec_i(exc_vec_i),
    .tlb_vec_i(tlb_vec_i), .status_i(status_i), .cause_i(cause_i), .tlbmisc_i(tlbmisc_i),
    .we_o(we_o), .status_o(status_o), .estatus_o(estatus_o), .bstatus_o(bstatus_o),
    .cause_o(cause_o), .tlbmisc_o(tlbmisc_o), .ea_o(ea_o), .ba_o(ba_o), .pc_o(pc_o),
    .semihost_o(semihost_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exc_st(input logic [31:0] s);
    return (s | EH) & ~(IE | U);
  endfunction

  function automatic logic [31:0] new_cause(input logic [4:0] c);
    return (cause_i & ~32'h7C) | (32'(c) << 2);
  endfunction

  task automatic fire(input logic [4:0] c, input logic [31:0] st, input logic [31:0] pc,
                      input logic [31:0] insn, input logic sem);
    @(negedge clk);
    code_i = c; status_i = st; pc_i = pc; insn_i = insn; semihost_en_i = sem; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  // order: status estatus bstatus cause tlbmisc ea ba pc
  task automatic expect_regs(input string tag, input logic [7:0] we_e,
      input logic [31:0] st, input logic [31:0] est, input logic [31:0] bst,
      input logic [31:0] cs, input logic [31:0] tm, input logic [31:0] ea,
      input logic [31:0] ba, input logic [31:0] pc, input logic sem);
    chk({tag, " R2 done"}, 32'(done_o), 32'd1);
    chk({tag, " we"}, 32'(we_o), 32'(we_e));
    chk({tag, " R10 semihost"}, 32'(semihost_o), 32'(sem));
    if (we_e[7]) chk({tag, " status"}, status_o, st);
    if (we_e[6]) chk({tag, " estatus"}, estatus_o, est);
    if (we_e[5]) chk({tag, " bstatus"}, bstatus_o, bst);
    if (we_e[4]) chk({tag, " R4 cause"}, cause_o, cs);
    if (we_e[3]) chk({tag, " tlbmisc"}, tlbmisc_o, tm);
    if (we_e[2]) chk({tag, " ea"}, ea_o, ea);
    if (we_e[1]) chk({tag, " ba"}, ba_o, ba);
    if (we_e[0]) chk({tag, " pc"}, pc_o, pc);
    @(negedge clk);
    chk({tag, " R2 done one cycle"}, 32'(done_o), 32'd0);
    chk({tag, " R2 we cleared"}, 32'(we_o), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 done", 32'(done_o), 0);
    chk("R1 we", 32'(we_o), 0);
    chk("R1 semihost", 32'(semihost_o), 0);
    chk("R1 err", 32'(err_o), 0);
  endtask

  task automatic t_irq();
    logic [31:0] s = 32'h0000_0F03;
    fire(5'd1, s, 32'h0000_4000, 32'h0, 1'b0);
    expect_regs("R3 irq", 8'b1101_0101, (s | IH) & ~(IE | U), s, 0,
                new_cause(5'd1), 0, 32'h0000_4004, 0, exc_vec_i, 1'b0);
    fire(5'd1, 32'h0000_0F02, 32'h0000_4100, 32'h0, 1'b0);
    expect_regs("R3 irq masked", 8'b0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
  endtask

  task automatic t_tlb_fast();
    logic [31:0] s = 32'h0000_0013;
    fire(5'd2, s, 32'h0000_8000, 32'h0, 1'b0);
    expect_regs("R5 fast miss", 8'b1101_1101, exc_st(s), s, 0, new_cause(5'd2),
                (tlbmisc_i & ~DBL) | WRB, 32'h0000_8004, 0, tlb_vec_i, 1'b0);
  endtask

  task automatic t_tlb_double();
    logic [31:0] s = 32'h0000_0007;
    tlbmisc_i = 32'h0000_F0F1;
    fire(5'd2, s, 32'h0000_8800, 32'h0, 1'b0);
    expect_regs("R6 double miss", 8'b1001_1001, exc_st(s), 0, 0, new_cause(5'd2),
                32'h0000_F0F3, 0, 0, exc_vec_i, 1'b0);
    tlbmisc_i = 32'h0000_F0F2;
  endtask

  task automatic t_perm();
    for (int c = 3; c <= 5; c++) begin
      logic [31:0] s = 32'h0000_0107;
      fire(5'(c), s, 32'h0000_9000 + 32'(c * 16), 32'h0, 1'b0);
      expect_regs($sformatf("R7 perm code %0d", c), 8'b1101_0101, exc_st(s), s, 0,
                  new_cause(5'(c)), 0, 32'h0000_9004 + 32'(c * 16), 0, exc_vec_i, 1'b0);
    end
  endtask

  task automatic t_nest();
    for (int c = 6; c <= 10; c++) begin
      logic [31:0] s = 32'h0000_0203;
      fire(5'(c), s, 32'h0000_A000, 32'h0, 1'b0);
      expect_regs($sformatf("R8 first code %0d", c), 8'b1101_0101, exc_st(s), s, 0,
                  new_cause(5'(c)), 0, 32'h0000_A004, 0, exc_vec_i, 1'b0);
      s = 32'h0000_0206;
      fire(5'(c), s, 32'h0000_A100, 32'h0, 1'b0);
      expect_regs($sformatf("R8 nested code %0d", c), 8'b1001_0001, exc_st(s), 0, 0,
                  new_cause(5'(c)), 0, 0, 0, exc_vec_i, 1'b0);
    end
  endtask

  task automatic t_break();
    logic [31:0] s = 32'h0000_0301;
    fire(5'd11, s, 32'h0000_B000, 32'h1234_5678, 1'b1);
    expect_regs("R9 break first", 8'b1011_0011, exc_st(s), 0, s,
                new_cause(5'd11), 0, 0, 32'h0000_B004, exc_vec_i, 1'b0);
    s = 32'h0000_0305;
    fire(5'd11, s, 32'h0000_B100, MAGIC, 1'b0);
    expect_regs("R9 break nested", 8'b1001_0001, exc_st(s), 0, 0,
                new_cause(5'd11), 0, 0, 0, exc_vec_i, 1'b0);
  endtask

  task automatic t_semi();
    fire(5'd11, 32'h0000_0003, 32'h0000_C000, MAGIC, 1'b1);
    expect_regs("R10 semihost", 8'b0000_0001, 0, 0, 0, 0, 0, 0, 0, 32'h0000_C004, 1'b1);
    chk("R10 semihost pulse ends", 32'(semihost_o), 0);
  endtask

  task automatic t_bad();
    fire(5'd0, 32'h0000_0003, 32'h0000_D000, 32'h0, 1'b0);
    expect_regs("R11 code 0", 8'b0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    chk("R11 err set", 32'(err_o), 1);
    fire(5'd1, 32'h0000_0001, 32'h0000_D100, 32'h0, 1'b0);
    expect_regs("R11 err after good", 8'b1101_0101, IH, 32'h1, 0, new_cause(5'd1),
                0, 32'h0000_D104, 0, exc_vec_i, 1'b0);
    chk("R11 err sticky", 32'(err_o), 1);
    fire(5'd20, 32'h0000_0003, 32'h0000_D200, 32'h0, 1'b0);
    expect_regs("R11 code 20", 8'b0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 err cleared by reset", 32'(err_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq();
    t_tlb_fast();
    t_tlb_double();
    t_perm();
    t_nest();
    t_break();
    t_semi();
    t_bad();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule